// File: doc/BRIEF.md
# Suspendable Synchronous Burst Read Port

This block is the read side of a 16-bit synchronous burst memory. A host holds chip enable low and pulses the address-valid strobe low for one clock to load a start address. The block then counts a fixed initial latency and puts one data word per clock on the data bus. A burst is 4, 8 or 16 words, or it runs on without end. Addresses either wrap inside an aligned window of the burst length or step linearly. A single-word mode repeats the start word for the whole burst. The storage is a fixed pattern computed from the address.

The host can park the burst at any point by raising output enable while chip enable stays low. It may also stop the clock during that time. The burst position and the mode settings stay frozen. When output enable returns low, the burst continues at the same word. If the park began inside the latency count, the latency is treated as complete, so the first word appears as soon as output enable falls. A WAIT flag marks cycles without valid data. What it shows outside the data words depends on whether the access is an array read or a status-type read. Both the flag and the data bus have their own drive enables, for the pads.

Top module: `sburst_rd_port`

## Requirements
- R1: After reset no burst is active: the data drive enable is 0. With chip and output enable low, the WAIT drive enable is 1 and WAIT is 0.
- R2: A rising clock edge with chip enable low and the address strobe low loads the address. The word at that address is driven after exactly LATENCY further rising edges. Word value for address a: upper byte = a[15:8] ^ a[23:16] ^ 0x5A, lower byte = a[7:0] ^ a[23:16] ^ 0x3C.
- R3: In linear mode, each rising edge in the data phase moves to the next address (start + k, modulo the address space).
- R4: In wrap mode with a fixed length N, word k comes from the N-aligned window holding the start address, at offset (start mod N + k) mod N.
- R5: The length code picks the burst length: 0 = 4 words, 1 = 8, 2 = 16, 3 = continuous. After the last word of a fixed burst, the data drive enable stays 0.
- R6: A continuous burst keeps stepping past 16 words in linear order, whatever the wrap input.
- R7: In single mode, every word of the burst is the start word.
- R8: While chip enable is low and output enable is high, the burst position does not move, however many edges pass. After output enable returns low, the same word is driven again. This may repeat within one burst.
- R9: If output enable is high on at least one edge during the latency count, the start word is driven in the same cycle that output enable returns low.
- R10: The WAIT drive enable is 0 whenever chip or output enable is high. The data drive enable is 0 then, and also whenever the data is not valid.
- R11: For an array read (status input 0 at the latch), WAIT is 1 during the latency count and during a boundary wait state. It is 0 while data is valid and after a fixed burst ends.
- R12: For a status-type read (status input 1 at the latch), WAIT is 1 in every cycle without valid data, including after the burst ends.
- R13: In linear or continuous stepping, when the next address falls on a 16-word boundary (low 4 bits zero), one cycle with no valid data and WAIT high is inserted before that word. Single mode and wrap windows never insert it.
- R14: Chip enable high on an edge ends the burst and returns to idle. Mode inputs are sampled only at the latch edge; later changes have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock; may be halted while the burst is parked |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; high while ce_n is low parks the burst |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_i | input | ADDR_W | Start word address |
| len_i | input | 2 | Burst length code (0:4, 1:8, 2:16, 3:continuous) |
| wrap_i | input | 1 | 1 = wrap inside the aligned window, 0 = linear |
| single_i | input | 1 | 1 = repeat the start word |
| status_i | input | 1 | 1 = status-type read WAIT policy |
| dq_o | output | DATA_W | Data word, zero when not driven |
| dq_en_o | output | 1 | Data pad drive enable |
| wait_o | output | 1 | WAIT flag, 1 = data not valid |
| wait_en_o | output | 1 | WAIT pad drive enable |

## Verification
The first word is due LATENCY rising edges after the latch edge. Each further word is due one edge after the one before, or two edges when a boundary wait state comes in between. The pad enables and WAIT follow chip and output enable in the same cycle, with no edge in between. The bench steps one edge at a time and samples 1 ns after each rising edge. For a change on output enable, it waits 1 ns after driving the change and samples before the next edge. A per-cycle model of the expected address and wait cycles is walked alongside each burst.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LAT  = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  localparam logic [1:0] LEN_CONT = 2'b11;

  // number of words for a length code; zero means no end
  function automatic logic [4:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      2'd2:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic is_wrapped(input logic [1:0] code, input logic wrap);
    return wrap && (code != LEN_CONT);
  endfunction

endpackage

// File: rtl/sbr_addr_gen.sv
module sbr_addr_gen
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ROW_W  = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] ofs_i,
  input  logic [1:0]        len_i,
  input  logic              wrap_i,
  input  logic              single_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              next_row_start_o
);

  // address of word ofs within the burst
  function automatic logic [ADDR_W-1:0] walk(
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] ofs,
    input logic [1:0]        code,
    input logic              wrap
  );
    logic [ADDR_W-1:0] mask;
    if (is_wrapped(code, wrap)) begin
      mask = ADDR_W'(burst_words(code)) - 1'b1;
      return (base & ~mask) | ((base + ofs) & mask);
    end
    return base + ofs;
  endfunction

  logic [ADDR_W-1:0] nxt_addr;

  always_comb begin
    cur_addr_o       = single_i ? base_i : walk(base_i, ofs_i, len_i, wrap_i);
    nxt_addr         = walk(base_i, ofs_i + 1'b1, len_i, wrap_i);
    next_row_start_o = !is_wrapped(len_i, wrap_i) && (nxt_addr[ROW_W-1:0] == '0);
  end

endmodule

// File: rtl/sbr_rom.sv
module sbr_rom #(
  parameter int              ADDR_W = 24,
  parameter int              DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED = 16'h5A3C
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] word_o
);

  function automatic logic [DATA_W-1:0] pattern(input logic [ADDR_W-1:0] a);
    logic [7:0] hi;
    hi = a[ADDR_W-1 -: 8];
    return a[DATA_W-1:0] ^ {(DATA_W/8){hi}} ^ SEED;
  endfunction

  assign word_o = pattern(addr_i);

endmodule

// File: rtl/sbr_seq.sv
module sbr_seq
  import sbr_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        len_i,
  input  logic              wrap_i,
  input  logic              single_i,
  input  logic              status_i,
  input  logic              next_row_start_i,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] ofs_q,
  output logic [1:0]        len_q,
  output logic              wrap_q,
  output logic              single_q,
  output logic              status_q,
  output phase_e            phase_q,
  output logic              bwait_q,
  output logic              word_step_o,
  output logic              data_valid_o
);

  localparam int LAT_W = $clog2(LATENCY) + 1;

  logic [LAT_W-1:0] lat_q;
  logic [4:0]       words;
  logic             active;
  logic             last_word;

  always_comb begin
    words        = burst_words(len_q);
    last_word    = (len_q != LEN_CONT) && (ofs_q == ADDR_W'(words - 5'd1));
    active       = !ce_n && adv_n && !oe_n;
    word_step_o  = active && (phase_q == PH_DATA) && !bwait_q && !last_word;
    data_valid_o = (phase_q == PH_DATA) && !bwait_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      lat_q    <= '0;
      base_q   <= '0;
      ofs_q    <= '0;
      bwait_q  <= 1'b0;
      len_q    <= 2'd0;
      wrap_q   <= 1'b0;
      single_q <= 1'b0;
      status_q <= 1'b0;
    end else if (ce_n) begin
      phase_q <= PH_IDLE;
      bwait_q <= 1'b0;
    end else if (!adv_n) begin
      phase_q  <= PH_LAT;
      lat_q    <= LAT_W'(LATENCY - 1);
      base_q   <= addr_i;
      ofs_q    <= '0;
      bwait_q  <= 1'b0;
      len_q    <= len_i;
      wrap_q   <= wrap_i;
      single_q <= single_i;
      status_q <= status_i;
    end else if (oe_n) begin
      // parked: sensing finishes, so a pending latency is complete
      if (phase_q == PH_LAT) phase_q <= PH_DATA;
    end else begin
      case (phase_q)
        PH_LAT: begin
          if (lat_q == '0) phase_q <= PH_DATA;
          else             lat_q   <= lat_q - 1'b1;
        end
        PH_DATA: begin
          if (bwait_q) begin
            bwait_q <= 1'b0;
          end else if (last_word) begin
            phase_q <= PH_DONE;
          end else begin
            ofs_q   <= ofs_q + 1'b1;
            bwait_q <= !single_q && next_row_start_i;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sbr_pads.sv
module sbr_pads #(
  parameter int DATA_W = 16
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              data_valid_i,
  input  logic              in_lat_i,
  input  logic              bwait_i,
  input  logic              status_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en_o,
  output logic              wait_o,
  output logic              wait_en_o
);

  logic bus_on;
  logic not_ready;

  always_comb begin
    bus_on    = !ce_n && !oe_n;
    not_ready = status_i ? !data_valid_i : (in_lat_i || bwait_i);
    wait_en_o = bus_on;
    wait_o    = bus_on && not_ready;
    dq_en_o   = bus_on && data_valid_i;
    dq_o      = dq_en_o ? word_i : '0;
  end

endmodule

// File: rtl/sburst_rd_port.sv
module sburst_rd_port
  import sbr_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int LATENCY = 4,
  parameter int ROW_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        len_i,
  input  logic              wrap_i,
  input  logic              single_i,
  input  logic              status_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en_o,
  output logic              wait_o,
  output logic              wait_en_o
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] ofs_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] word;
  logic [1:0]        len_q;
  logic              wrap_q;
  logic              single_q;
  logic              status_q;
  logic              bwait_q;
  logic              next_row_start;
  logic              word_step;
  logic              data_valid;
  phase_e            phase_q;

  // named events for the checker
  logic in_lat;
  logic busy;
  logic idle;
  assign in_lat = (phase_q == PH_LAT);
  assign busy   = (phase_q == PH_LAT) || (phase_q == PH_DATA);
  assign idle   = (phase_q == PH_IDLE);

  sbr_seq #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .ce_n             (ce_n),
    .oe_n             (oe_n),
    .adv_n            (adv_n),
    .addr_i           (addr_i),
    .len_i            (len_i),
    .wrap_i           (wrap_i),
    .single_i         (single_i),
    .status_i         (status_i),
    .next_row_start_i (next_row_start),
    .base_q           (base_q),
    .ofs_q            (ofs_q),
    .len_q            (len_q),
    .wrap_q           (wrap_q),
    .single_q         (single_q),
    .status_q         (status_q),
    .phase_q          (phase_q),
    .bwait_q          (bwait_q),
    .word_step_o      (word_step),
    .data_valid_o     (data_valid)
  );

  sbr_addr_gen #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_addr (
    .base_i           (base_q),
    .ofs_i            (ofs_q),
    .len_i            (len_q),
    .wrap_i           (wrap_q),
    .single_i         (single_q),
    .cur_addr_o       (cur_addr),
    .next_row_start_o (next_row_start)
  );

  sbr_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .addr_i (cur_addr),
    .word_o (word)
  );

  sbr_pads #(.DATA_W(DATA_W)) u_pads (
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .data_valid_i (data_valid),
    .in_lat_i     (in_lat),
    .bwait_i      (bwait_q),
    .status_i     (status_q),
    .word_i       (word),
    .dq_o         (dq_o),
    .dq_en_o      (dq_en_o),
    .wait_o       (wait_o),
    .wait_en_o    (wait_en_o)
  );

endmodule

// File: rtl/sbr_chk.sv
module sbr_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              adv_n,
  input logic              busy,
  input logic              in_lat,
  input logic              idle,
  input logic              word_step,
  input logic              status_q,
  input logic [ADDR_W-1:0] ofs_q,
  input logic              dq_en_o,
  input logic              wait_o,
  input logic              wait_en_o
);

  // R2
  latch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_n) |=> (in_lat && !dq_en_o));

  // R3
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_step |=> (ofs_q == $past(ofs_q) + 1'b1));

  // R8
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ce_n && adv_n && oe_n) |=> $stable(ofs_q));

  // R11
  valid_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en_o |-> (wait_en_o && !wait_o));

  // R12
  status_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en_o && status_q && !dq_en_o) |-> wait_o);

  // R14
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> idle);

endmodule

bind sburst_rd_port sbr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .adv_n     (adv_n),
  .busy      (busy),
  .in_lat    (in_lat),
  .idle      (idle),
  .word_step (word_step),
  .status_q  (status_q),
  .ofs_q     (ofs_q),
  .dq_en_o   (dq_en_o),
  .wait_o    (wait_o),
  .wait_en_o (wait_en_o)
);

// File: tb/tb_sburst_rd_port.sv
`timescale 1ns/1ps
module tb_sburst_rd_port;

  localparam int AW  = 24;
  localparam int DW  = 16;
  localparam int LAT = 4;
  localparam int NV  = 8;

  // [39:32] words checked, [28] status, [27] single, [26] wrap, [25:24] len, [23:0] addr
  localparam logic [39:0] VECS [NV] = '{
    {8'd4,  3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h000100},
    {8'd8,  3'b000, 1'b0, 1'b0, 1'b1, 2'd1, 24'h00010E},
    {8'd8,  3'b000, 1'b0, 1'b0, 1'b0, 2'd1, 24'h00010E},
    {8'd16, 3'b000, 1'b1, 1'b0, 1'b1, 2'd2, 24'h123456},
    {8'd20, 3'b000, 1'b0, 1'b0, 1'b0, 2'd3, 24'h0000F9},
    {8'd8,  3'b000, 1'b0, 1'b1, 1'b0, 2'd1, 24'h000033},
    {8'd4,  3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 24'hFFFFFE},
    {8'd20, 3'b000, 1'b0, 1'b0, 1'b1, 2'd3, 24'h000205}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [1:0]    len = 2'd0;
  logic          wrap = 1'b0, single = 1'b0, status = 1'b0;
  logic [DW-1:0] dq;
  logic          dq_en, wt, wt_en;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sburst_rd_port #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n),
    .addr_i(addr), .len_i(len), .wrap_i(wrap), .single_i(single), .status_i(status),
    .dq_o(dq), .dq_en_o(dq_en), .wait_o(wt), .wait_en_o(wt_en)
  );

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
    return {a[15:8] ^ a[23:16] ^ 8'h5A, a[7:0] ^ a[23:16] ^ 8'h3C};
  endfunction

  function automatic int len_words(input logic [1:0] c);
    return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : (c == 2'd2) ? 16 : 0;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k,
                                             input logic [1:0] c, input logic w, input logic s);
    int n;
    int lo;
    if (s) return b;
    if (w && c != 2'd3) begin
      n  = len_words(c);
      lo = int'(b) % n;
      return b - AW'(lo) + AW'((lo + k) % n);
    end
    return b + AW'(k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic start(input logic [AW-1:0] a, input logic [1:0] c,
                       input logic w, input logic s, input logic st);
    addr = a; len = c; wrap = w; single = s; status = st;
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0;
    tick();
    adv_n = 1'b1;
  endtask

  task automatic wait_latency();
    for (int i = 0; i < LAT; i++) begin
      check("R2 latency no data", {31'd0, dq_en}, 32'd0);
      check("R11 latency WAIT", {31'd0, wt}, 32'd1);
      tick();
    end
  endtask

  task automatic run_vec(input logic [39:0] v);
    logic [AW-1:0] b;
    logic [1:0]    c;
    logic          w, s, st;
    int            n;
    logic [AW-1:0] ea;
    b = v[23:0]; c = v[25:24]; w = v[26]; s = v[27]; st = v[28]; n = int'(v[39:32]);
    start(b, c, w, s, st);
    wait_latency();
    for (int k = 0; k < n; k++) begin
      ea = exp_addr(b, k, c, w, s);
      if (k > 0 && !s && !(w && c != 2'd3) && ea[3:0] == 4'h0) begin
        check("R13 boundary wait no data", {31'd0, dq_en}, 32'd0);
        check("R13 boundary WAIT", {31'd0, wt}, 32'd1);
        tick();
      end
      check("R3 R4 R6 R7 data valid", {31'd0, dq_en}, 32'd1);
      check("R3 R4 R6 R7 word", {16'd0, dq}, {16'd0, exp_word(ea)});
      check("R11 WAIT low on data", {31'd0, wt}, 32'd0);
      tick();
    end
    if (c != 2'd3) begin
      check("R5 burst ended", {31'd0, dq_en}, 32'd0);
      check("R11 R12 end-of-burst WAIT", {31'd0, wt}, {31'd0, st});
    end
    ce_n = 1'b1;
    tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #23 rst_n = 1'b1;
    tick();
    check("R1 idle dq_en", {31'd0, dq_en}, 32'd0);
    check("R1 idle wait_en off", {31'd0, wt_en}, 32'd0);
    ce_n = 1'b0; oe_n = 1'b0;
    #1;
    check("R1 idle dq_en selected", {31'd0, dq_en}, 32'd0);
    check("R1 idle wait_en", {31'd0, wt_en}, 32'd1);
    check("R1 idle WAIT", {31'd0, wt}, 32'd0);
    ce_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8 R10: park twice in the data phase
    start(24'h000040, 2'd2, 1'b0, 1'b0, 1'b0);
    wait_latency();
    tick();
    check("R3 second word", {16'd0, dq}, {16'd0, exp_word(24'h000041)});
    oe_n = 1'b1;
    #1;
    check("R10 parked dq_en", {31'd0, dq_en}, 32'd0);
    check("R10 parked wait_en", {31'd0, wt_en}, 32'd0);
    for (int i = 0; i < 5; i++) tick();
    oe_n = 1'b0;
    #1;
    check("R8 resume same word", {16'd0, dq}, {16'd0, exp_word(24'h000041)});
    check("R8 resume valid", {31'd0, dq_en}, 32'd1);
    tick();
    check("R8 step after resume", {16'd0, dq}, {16'd0, exp_word(24'h000042)});
    oe_n = 1'b1;
    tick(); tick(); tick();
    oe_n = 1'b0;
    #1;
    check("R8 second resume", {16'd0, dq}, {16'd0, exp_word(24'h000042)});
    tick();
    check("R8 step after second resume", {16'd0, dq}, {16'd0, exp_word(24'h000043)});
    ce_n = 1'b1;
    #1;
    check("R10 deselect wait_en", {31'd0, wt_en}, 32'd0);
    tick();

    // R9: park during latency
    start(24'h000080, 2'd0, 1'b0, 1'b0, 1'b0);
    tick();
    oe_n = 1'b1;
    tick(); tick();
    oe_n = 1'b0;
    #1;
    check("R9 word0 on resume", {16'd0, dq}, {16'd0, exp_word(24'h000080)});
    check("R9 valid on resume", {31'd0, dq_en}, 32'd1);
    tick();
    check("R9 next word", {16'd0, dq}, {16'd0, exp_word(24'h000081)});
    ce_n = 1'b1;
    tick();

    // R14: mode changes after latch ignored
    start(24'h000010, 2'd0, 1'b0, 1'b0, 1'b0);
    len = 2'd3; wrap = 1'b1; single = 1'b1; status = 1'b1;
    wait_latency();
    for (int k = 0; k < 4; k++) begin
      check("R14 latched mode word", {16'd0, dq}, {16'd0, exp_word(24'h000010 + AW'(k))});
      tick();
    end
    check("R14 latched length ends", {31'd0, dq_en}, 32'd0);
    check("R14 latched array WAIT", {31'd0, wt}, 32'd0);
    ce_n = 1'b1;
    tick();

    // R14: chip enable high aborts mid-burst
    start(24'h000500, 2'd3, 1'b0, 1'b0, 1'b0);
    wait_latency();
    tick();
    ce_n = 1'b1;
    tick();
    ce_n = 1'b0;
    #1;
    check("R14 abort no data", {31'd0, dq_en}, 32'd0);
    check("R14 abort idle WAIT", {31'd0, wt}, 32'd0);
    tick();
    check("R14 abort stays idle", {31'd0, dq_en}, 32'd0);
    ce_n = 1'b1;
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule